// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a general-purpose I/O port of up to 32 lines with a small word-wide register set on a simple bus. Software writes the driven level of each line, chooses per line whether the line is an input or an output, can make any output line blink, and can invert each input line before it is read. Reads use a byte address, and the two low address bits are ignored.

A direction bit set to one makes its line an input with the output driver switched off. Clearing the bit turns the driver on. A line whose blink bit is set drives a shared square wave instead of its stored output value. That square wave comes from a free-running prescaler with a 50% duty cycle. Input lines pass through a two-stage synchronizer, and are then exclusive-ORed with their inversion bit when the input data register is read. Interrupt logic is kept in a separate block.

Top module: `gpio_port_regs`

## Requirements
- R1: Within a few cycles after reset the output-data, blink-enable and inversion registers read 0. The direction register reads 1 on every implemented line, so `pin_oe` is all zero and every line starts as an input.
- R2: Register offsets are output data 0x00, direction 0x04, blink enable 0x08, inversion 0x0C and input data 0x10. A write takes effect at the clock edge on which it is presented. A read returns the addressed register combinationally while `bus_sel` is high. Address bits [1:0] are ignored.
- R3: A direction bit of 1 gives `pin_oe` = 0 for that line (input). A direction bit of 0 gives `pin_oe` = 1 (driven).
- R4: A line with blink enable 0 drives its output-data bit on `pin_out`.
- R5: A line with blink enable 1 drives a common blink phase on `pin_out`. The phase starts at 0 after reset and toggles every BLINK_HALF cycles, giving a 50% duty cycle. All blinking lines carry the same phase.
- R6: The input data register returns each synchronized line XORed with its inversion bit. An inversion bit of 0 passes the line unchanged and a bit of 1 inverts it. A change of an inversion bit shows at once.
- R7: A change on `pin_in` that is set up before clock edge k is still invisible to a read taken between edges k and k+1. It is visible to a read taken after edge k+1.
- R8: Register bits at and above NUM_LINES read as 0, and writes to those bits are ignored.
- R9: Writes to the input data register and to unmapped offsets change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| pin_in | input | NUM_LINES | Line levels from the pads |
| pin_out | output | NUM_LINES | Driven level per line |
| pin_oe | output | NUM_LINES | Output enable per line, 1 = driven |

## Verification
The bench builds the block with NUM_LINES = 20 and BLINK_HALF = 4. With 20 lines, upper register bits exist in every 32-bit word, so the read-as-zero and write-ignored rule on unimplemented bits can be observed. A half period of four cycles lets an eight-cycle window hold a whole blink period, so both the duty cycle and the shared phase of two blinking lines can be checked in a few cycles. The input path is sampled one cycle and two cycles after a pin change to pin down the two-stage latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int BUS_W = 32;
  localparam int MAX_LINES = 32;

  // word indices (byte offset / 4)
  localparam int WIDX_OUT   = 0;
  localparam int WIDX_DIR   = 1;
  localparam int WIDX_BLINK = 2;
  localparam int WIDX_INV   = 3;
  localparam int WIDX_DIN   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_DIR,
    SEL_BLINK,
    SEL_INV,
    SEL_DIN
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [W-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = d;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int HALF = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             tick;

  always_comb begin
    tick    = (cnt_q == LAST);
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    phase_d = phase_q ^ tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int W = 32
) (
  input  logic [W-1:0] out_val,
  input  logic [W-1:0] blink_en,
  input  logic [W-1:0] dir_in,
  input  logic         phase,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign pin_out[i] = blink_en[i] ? phase : out_val[i];
    assign pin_oe[i]  = ~dir_in[i];
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 12_500_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int PAD_W  = BUS_W - NUM_LINES;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic [WORD_W-1:0] word_idx;
  reg_sel_e          sel;
  assign word_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    if      (word_idx == WORD_W'(WIDX_OUT))   sel = SEL_OUT;
    else if (word_idx == WORD_W'(WIDX_DIR))   sel = SEL_DIR;
    else if (word_idx == WORD_W'(WIDX_BLINK)) sel = SEL_BLINK;
    else if (word_idx == WORD_W'(WIDX_INV))   sel = SEL_INV;
    else if (word_idx == WORD_W'(WIDX_DIN))   sel = SEL_DIN;
    else                                      sel = SEL_NONE;
  end

  // register file
  logic [NUM_LINES-1:0] out_q, dir_q, blink_q, inv_q;
  logic [NUM_LINES-1:0] out_d, dir_d, blink_d, inv_d;
  logic                 wr_en;
  logic [NUM_LINES-1:0] wr_val;

  assign wr_en  = bus_sel & bus_we;
  assign wr_val = bus_wdata[NUM_LINES-1:0];

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    blink_d = blink_q;
    inv_d   = inv_q;
    if (wr_en) begin
      unique case (sel)
        SEL_OUT:   out_d   = wr_val;
        SEL_DIR:   dir_d   = wr_val;
        SEL_BLINK: blink_d = wr_val;
        SEL_INV:   inv_d   = wr_val;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      inv_q   <= '0;
    end else if (wr_en) begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      inv_q   <= inv_d;
    end
  end

  // input path
  logic [NUM_LINES-1:0] sync_q;
  logic [NUM_LINES-1:0] din_val;

  gpio_in_sync #(.W(NUM_LINES)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_in),
    .q     (sync_q)
  );
  assign din_val = sync_q ^ inv_q;

  // blink and pin drive
  logic blink_phase;

  gpio_blink_gen #(.HALF(BLINK_HALF)) i_blink (
    .clk   (clk),
    .rst_n (rst_int_n),
    .phase (blink_phase)
  );

  gpio_pin_drive #(.W(NUM_LINES)) i_drive (
    .out_val  (out_q),
    .blink_en (blink_q),
    .dir_in   (dir_q),
    .phase    (blink_phase),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  // read mux
  logic [NUM_LINES-1:0] rd_val;
  always_comb begin
    unique case (sel)
      SEL_OUT:   rd_val = out_q;
      SEL_DIR:   rd_val = dir_q;
      SEL_BLINK: rd_val = blink_q;
      SEL_INV:   rd_val = inv_q;
      SEL_DIN:   rd_val = din_val;
      default:   rd_val = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_rdata = bus_sel ? {{PAD_W{1'b0}}, rd_val} : '0;
    end else begin : g_full
      assign bus_rdata = bus_sel ? rd_val : '0;
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 4
) (
  input logic                 clk,
  input logic                 rst_int_n,
  input logic                 bus_sel,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] pin_in,
  input logic [NUM_LINES-1:0] pin_out,
  input logic [NUM_LINES-1:0] pin_oe,
  input logic [NUM_LINES-1:0] out_q,
  input logic [NUM_LINES-1:0] dir_q,
  input logic [NUM_LINES-1:0] blink_q,
  input logic [NUM_LINES-1:0] inv_q,
  input logic                 blink_phase
);
  localparam int RUN_W = $clog2(BLINK_HALF + 1) + 1;
  localparam logic [31:0] IMPL = (NUM_LINES >= 32) ? 32'hFFFF_FFFF
                                                   : ((32'h1 << NUM_LINES) - 32'h1);

  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  logic [1:0]       age_q;
  logic             prev_phase_q;
  logic [RUN_W-1:0] run_q;
  logic             toggled;
  assign toggled = (blink_phase != prev_phase_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      age_q        <= '0;
      prev_phase_q <= 1'b0;
      run_q        <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
      prev_phase_q <= blink_phase;
      if (toggled)                          run_q <= RUN_W'(1);
      else if (run_q != RUN_W'(BLINK_HALF)) run_q <= run_q + 1'b1;
    end
  end

  // R3
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && bus_we && widx == (ADDR_W-2)'(WIDX_DIR))
      |=> (pin_oe == ~$past(bus_wdata[NUM_LINES-1:0])));

  // R4
  out_static_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && bus_we && widx == (ADDR_W-2)'(WIDX_OUT) && blink_q == '0)
      |=> (pin_out == $past(bus_wdata[NUM_LINES-1:0])));

  // R5
  blink_period_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    toggled |-> (run_q == RUN_W'(BLINK_HALF)));

  // R7
  din_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3 && bus_sel && !bus_we && widx == (ADDR_W-2)'(WIDX_DIN))
      |-> (bus_rdata[NUM_LINES-1:0] == ($past(pin_in, 2) ^ inv_q)));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rdata & ~IMPL) == 32'h0);

  // R9
  din_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && bus_we && widx == (ADDR_W-2)'(WIDX_DIN))
      |=> ($stable(out_q) && $stable(dir_q) && $stable(blink_q) && $stable(inv_q)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NUM_LINES  (NUM_LINES),
  .ADDR_W     (ADDR_W),
  .BLINK_HALF (BLINK_HALF)
) i_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .out_q       (out_q),
  .dir_q       (dir_q),
  .blink_q     (blink_q),
  .inv_q       (inv_q),
  .blink_phase (blink_phase)
);

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;
  localparam int NL = 20;
  localparam int AW = 8;
  localparam int HALF = 4;
  localparam logic [31:0] MASK = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NL-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_regs #(.NUM_LINES(NL), .ADDR_W(AW), .BLINK_HALF(HALF)) i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    rd(8'h00, v); check("R1 out", v, 32'h0);
    rd(8'h04, v); check("R1 dir", v, MASK);
    rd(8'h08, v); check("R1 blink", v, 32'h0);
    rd(8'h0C, v); check("R1 inv", v, 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_0000);
    rd(8'h04, v); check("R8 dir upper", v, 32'h000F_0000);
    check("R3 pin_oe", 32'(pin_oe), 32'h0000_FFFF);
  endtask

  task automatic t_out;
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_A5A5);
    rd(8'h00, v); check("R2/R8 out read", v, 32'h0005_A5A5);
    check("R4 pin_out static", 32'(pin_out), 32'h0005_A5A5);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(8'h10, 32'h1234_5678);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R9 out kept", v, 32'h0005_A5A5);
    rd(8'h04, v); check("R9 dir kept", v, 32'h000F_0000);
    rd(8'h08, v); check("R9 blink kept", v, 32'h0);
    rd(8'h0C, v); check("R9 inv kept", v, 32'h0);
    rd(8'h1C, v); check("R9 unmapped read", v, 32'h0);
    check("R9 pin_out kept", 32'(pin_out), 32'h0005_A5A5);
  endtask

  task automatic t_input;
    logic [31:0] v;
    wr(8'h0D, 32'h0);
    @(negedge clk);
    pin_in = 20'h12345;
    @(negedge clk);
    rd(8'h10, v); check("R7 one edge", v, 32'h0);
    @(negedge clk);
    rd(8'h10, v); check("R7 two edges", v, 32'h0001_2345);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R2 addr low bits", v, MASK);
    rd(8'h10, v); check("R6 inverted", v, 32'h000E_DCBA);
    wr(8'h0C, 32'h0000_00F0);
    rd(8'h10, v); check("R6 partial", v, 32'h0001_23B5);
  endtask

  task automatic t_blink;
    int hi0, hi3, diff, togg;
    logic prev;
    wr(8'h08, 32'h0000_0009);
    hi0 = 0; hi3 = 0; diff = 0; togg = 0;
    prev = pin_out[0];
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      hi0 += int'(pin_out[0]);
      hi3 += int'(pin_out[3]);
      if (pin_out[0] != pin_out[3]) diff++;
      if (pin_out[0] != prev) togg++;
      prev = pin_out[0];
    end
    check("R5 duty line0", 32'(hi0), 32'd4);
    check("R5 duty line3", 32'(hi3), 32'd4);
    check("R5 common phase", 32'(diff), 32'd0);
    check("R5 toggles", 32'(togg), 32'd2);
    check("R4 others static", 32'(pin_out & 20'hFFFF6), 32'h0005_A5A4);
    wr(8'h08, 32'h0);
    check("R4 blink off", 32'(pin_out), 32'h0005_A5A5);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir();
    t_out();
    t_ignored();
    t_input();
    t_blink();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule